// File: doc/BRIEF.md
# Dual DAC Update Sequencer

This block sits in a host FPGA and drives a two-channel 10-bit serial DAC over three wires: an active-low select, a serial clock and a data line. A requester asks for one of four operations: load channel A, load channel B, load both so that they change together, or put the converter into power-down. A speed flag goes with each request. The block assembles the 16-bit command words, divides the system clock down to the serial clock, and frames each word with the select timing the converter needs.

The serial clock rests high between frames, so the first edge inside every frame is a falling edge. The converter samples data on falling edges, so the data line only moves on rising edges. After the select line goes high, one more rising clock edge is produced to reset the converter's receive logic. A two-channel update is sent as two frames. The first loads channel B's value into the converter's holding buffer. The second writes channel A, which also moves the buffer to channel B, so both outputs change together. Requests are taken only while `busy` is low. `done` pulses once when the whole operation, including its final rearm edge, is finished.

Top module: `dual_dac_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `dac_cs_n` is 1, `dac_sclk` is 1, `busy` is 0 and `done` is 0.
- R2: Each frame carries 16 bits, most significant first, one per falling `dac_sclk` edge. `dac_din` changes only together with a rising `dac_sclk` edge or a falling `dac_cs_n` edge, so it is stable around every falling edge.
- R3: Word layout: bit 15 is the high select bit, bit 14 the speed bit (1 = fast, copied from `req_fast`), bit 13 the power-down bit, bit 12 the low select bit, bits 11..2 the 10-bit code, bits 1..0 zero.
- R4: `req_op` 0 (set A) sends one frame with select bits 1,0 (high,low), power-down bit 0 and `req_code_a`. `req_op` 1 (set B) sends one frame with select bits 0,0, power-down bit 0 and `req_code_b`.
- R5: `req_op` 2 (set both) sends two frames. The first has select bits 0,1 and `req_code_b`. The second has select bits 1,0 and `req_code_a`. Both have power-down bit 0.
- R6: `req_op` 3 (power-down) sends one frame with bit 13 set, select bits 0,1 and `req_code_b` in the code field, so the converter's buffer keeps channel B's value.
- R7: Each frame has exactly 16 falling `dac_sclk` edges while `dac_cs_n` is low. `dac_cs_n` falls at least SETUP_CYC + HALF_CYC clock cycles before the first falling edge. It rises, with `dac_sclk` low, at least HOLD_CYC cycles after the 16th.
- R8: After every rise of `dac_cs_n`, a rising `dac_sclk` edge happens with select high before the next fall of `dac_cs_n` and before `done`. Between frames `dac_sclk` rests high.
- R9: Every high and every low phase of `dac_sclk` lasts at least HALF_CYC system clock cycles.
- R10: A request with `req_valid` high is taken on a rising clock edge only when `busy` is low, and `busy` is 1 from the next cycle on. Requests while `busy` is high are ignored. `done` is a single-cycle pulse, and `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | Operation: 0 set A, 1 set B, 2 set both, 3 power-down |
| req_fast | input | 1 | Speed bit for the words of this request |
| req_code_a | input | CODE_W | Code for channel A |
| req_code_b | input | CODE_W | Code for channel B (and the buffer) |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| dac_cs_n | output | 1 | Active-low converter select |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_din | output | 1 | Serial data to the converter |

## Verification
The two events that can fall in the same cycle are the end of an operation and the arrival of a new request. The `done` pulse and a `req_valid` that is already waiting share a cycle. The bench holds a channel-B request high across the `done` cycle of a channel-A update. It then judges that the request is taken on the very next edge, that exactly one frame of each operation reaches the converter model, and that the rearm edge still comes before the second select fall. A related case pulses a request in the middle of a frame and checks, at the data pins, that no extra frame ever appears.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  typedef enum logic [1:0] {
    OP_SET_A    = 2'd0,
    OP_SET_B    = 2'd1,
    OP_SET_BOTH = 2'd2,
    OP_PDOWN    = 2'd3
  } dds_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_REARM = 3'd5,
    ST_GAP   = 3'd6
  } dds_state_e;

endpackage

// File: rtl/dds_word_fmt.sv
`timescale 1ns/1ps
// Builds the command words for one request: the first word combinationally
// (loaded into the shifter in the accept cycle), the second word registered.
module dds_word_fmt
  import dds_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [1:0]          op,
  input  logic                fast,
  input  logic [CODE_W-1:0]   code_a,
  input  logic [CODE_W-1:0]   code_b,
  output logic [CODE_W+5:0]   first_word,
  output logic [CODE_W+5:0]   second_word,
  output logic                two_frames
);

  localparam int FW = CODE_W + 6;

  function automatic logic [FW-1:0] pack(input logic sel_hi, input logic sel_lo,
                                         input logic spd, input logic pwr,
                                         input logic [CODE_W-1:0] code);
    return {sel_hi, spd, pwr, sel_lo, code, 2'b00};
  endfunction

  always_comb begin
    case (dds_op_e'(op))
      OP_SET_A:    first_word = pack(1'b1, 1'b0, fast, 1'b0, code_a);
      OP_SET_B:    first_word = pack(1'b0, 1'b0, fast, 1'b0, code_b);
      OP_SET_BOTH: first_word = pack(1'b0, 1'b1, fast, 1'b0, code_b);
      default:     first_word = pack(1'b0, 1'b1, fast, 1'b1, code_b);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      second_word <= '0;
      two_frames  <= 1'b0;
    end else if (capture) begin
      second_word <= pack(1'b1, 1'b0, fast, 1'b0, code_a);
      two_frames  <= (dds_op_e'(op) == OP_SET_BOTH);
    end
  end

endmodule

// File: rtl/dds_timer.sv
`timescale 1ns/1ps
// Down-counting phase timer: a phase of N cycles is loaded with N-1.
module dds_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dds_shreg.sv
`timescale 1ns/1ps
// MSB-first parallel-load shift register; its top bit drives the data pin.
module dds_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

endmodule

// File: rtl/dual_dac_sequencer.sv
`timescale 1ns/1ps
module dual_dac_sequencer
  import dds_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int HALF_CYC  = 5,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_fast,
  input  logic [CODE_W-1:0] req_code_a,
  input  logic [CODE_W-1:0] req_code_b,
  output logic              busy,
  output logic              done,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_din
);

  localparam int FRAME_W = CODE_W + 6;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int T_AB    = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int T_MAX   = (T_AB > HOLD_CYC) ? T_AB : HOLD_CYC;
  localparam int TMR_W   = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [TMR_W-1:0] T_HALF  = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);

  dds_state_e         state;
  logic [BIT_W-1:0]   bit_cnt;
  logic               second;
  logic               accept;
  logic [FRAME_W-1:0] first_word;
  logic [FRAME_W-1:0] second_word;
  logic               two_frames;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_expired;
  logic               sh_load;
  logic [FRAME_W-1:0] sh_val;
  logic               sh_shift;
  logic               more_frames;

  assign accept      = (state == ST_IDLE) && req_valid;
  assign more_frames = two_frames && !second;

  dds_word_fmt #(.CODE_W(CODE_W)) u_fmt (
    .clk        (clk),
    .rst        (rst),
    .capture    (accept),
    .op         (req_op),
    .fast       (req_fast),
    .code_a     (req_code_a),
    .code_b     (req_code_b),
    .first_word (first_word),
    .second_word(second_word),
    .two_frames (two_frames)
  );

  dds_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  dds_shreg #(.W(FRAME_W)) u_sr (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .load_val(sh_val),
    .shift   (sh_shift),
    .msb     (dac_din)
  );

  // Timer reload and shifter control for each phase transition.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = T_HALF;
    sh_load  = 1'b0;
    sh_val   = first_word;
    sh_shift = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          sh_load  = 1'b1;
        end
      end
      ST_SETUP, ST_HIGH, ST_HOLD, ST_REARM: begin
        tmr_load = tmr_expired;
      end
      ST_LOW: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (bit_cnt == LAST_BIT) tmr_val = T_HOLD;
          else                     sh_shift = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_expired && more_frames) begin
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          sh_load  = 1'b1;
          sh_val   = second_word;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      second   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dac_cs_n <= 1'b1;
      dac_sclk <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SETUP;
            busy     <= 1'b1;
            second   <= 1'b0;
            bit_cnt  <= '0;
            dac_cs_n <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tmr_expired) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (tmr_expired) begin
            dac_sclk <= 1'b0;
            state    <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmr_expired) begin
            if (bit_cnt == LAST_BIT) begin
              state <= ST_HOLD;
            end else begin
              dac_sclk <= 1'b1;
              bit_cnt  <= bit_cnt + 1'b1;
              state    <= ST_HIGH;
            end
          end
        end
        ST_HOLD: begin
          if (tmr_expired) begin
            dac_cs_n <= 1'b1;
            state    <= ST_REARM;
          end
        end
        ST_REARM: begin
          if (tmr_expired) begin
            dac_sclk <= 1'b1;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_expired) begin
            if (more_frames) begin
              second   <= 1'b1;
              bit_cnt  <= '0;
              dac_cs_n <= 1'b0;
              state    <= ST_SETUP;
            end else begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dds_sva.sv
`timescale 1ns/1ps
module dds_sva #(
  parameter int HALF_CYC = 5,
  parameter int FRAME_W  = 16
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic din
);

  localparam int RUN_W = $clog2(HALF_CYC + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             prev_sclk;
  logic             prev_cs_n;
  logic [7:0]       fall_cnt;
  logic             rearm_pend;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk  <= 1'b1;
      prev_cs_n  <= 1'b1;
      fall_cnt   <= '0;
      rearm_pend <= 1'b0;
      run        <= '0;
    end else begin
      prev_sclk <= sclk;
      prev_cs_n <= cs_n;
      if (cs_n)                         fall_cnt <= '0;
      else if (prev_sclk && !sclk)      fall_cnt <= fall_cnt + 1'b1;
      if (cs_n && !prev_cs_n)           rearm_pend <= 1'b1;
      else if (cs_n && sclk && !prev_sclk) rearm_pend <= 1'b0;
      if (sclk != prev_sclk)            run <= RUN_W'(1);
      else if (run != RUN_MAX)          run <= run + 1'b1;
    end
  end

  a_r2_din_stable_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(din));
  a_r2_din_moves_on_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(din) |-> ($rose(sclk) || $fell(cs_n)));
  a_r7_fall_only_selected: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> !cs_n);
  a_r7_sixteen_falls: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (fall_cnt == 8'(FRAME_W)));
  a_r7_deselect_clock_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sclk);
  a_r8_select_clock_high: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk);
  a_r8_rearm_before_select: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !rearm_pend);
  a_r8_rearm_before_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !rearm_pend);
  a_r9_sclk_min_width: assert property (@(posedge clk) disable iff (rst)
    (sclk != prev_sclk) |-> (run >= RUN_W'(HALF_CYC)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind dual_dac_sequencer dds_sva #(.HALF_CYC(HALF_CYC), .FRAME_W(CODE_W + 6)) u_dds_sva (
  .clk (clk),
  .rst (rst),
  .busy(busy),
  .done(done),
  .cs_n(dac_cs_n),
  .sclk(dac_sclk),
  .din (dac_din)
);

// File: tb/dual_dac_sequencer_tb_top.sv
`timescale 1ns/1ps
module dual_dac_sequencer_tb_top;

  localparam int HALF = 5;
  localparam int SU   = 2;
  localparam int HO   = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic       req_fast = 1'b0;
  logic [9:0] req_code_a = '0;
  logic [9:0] req_code_b = '0;
  logic       busy, done, dac_cs_n, dac_sclk, dac_din;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  dual_dac_sequencer #(.CODE_W(10), .HALF_CYC(HALF), .SETUP_CYC(SU), .HOLD_CYC(HO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_fast(req_fast),
    .req_code_a(req_code_a), .req_code_b(req_code_b), .busy(busy), .done(done),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_din(dac_din)
  );

  // Converter-side model: captures frames and measures timing.
  logic [15:0] sh = '0;
  int nb = 0, nfr = 0, rearm_err = 0, rearm_pend = 0;
  logic [15:0] fr_word [8];
  int fr_bits [8];
  int t_csf = 0, t_first = 0, t_lastf = 0, t_edge = 0;
  int min_su = 1000000, min_ho = 1000000, min_hi = 1000000, min_lo = 1000000;

  always @(negedge dac_sclk) begin
    if (cyc - t_edge < min_hi) min_hi = cyc - t_edge;
    t_edge = cyc;
    if (!dac_cs_n) begin
      sh = {sh[14:0], dac_din};
      nb++;
      if (nb == 1 && (cyc - t_csf) < min_su) min_su = cyc - t_csf;
      t_lastf = cyc;
    end
  end
  always @(posedge dac_sclk) begin
    if (cyc - t_edge < min_lo) min_lo = cyc - t_edge;
    t_edge = cyc;
    if (dac_cs_n) rearm_pend = 0;
  end
  always @(negedge dac_cs_n) begin
    if (rearm_pend != 0) rearm_err++;
    sh = '0; nb = 0; t_csf = cyc;
  end
  always @(posedge dac_cs_n) begin
    if (nfr < 8) begin fr_word[nfr] = sh; fr_bits[nfr] = nb; end
    nfr++;
    if ((cyc - t_lastf) < min_ho) min_ho = cyc - t_lastf;
    rearm_pend = 1;
  end

  function automatic logic [15:0] mkw(input bit hi, input bit lo, input bit spd,
                                      input bit pwr, input logic [9:0] c);
    return {hi, spd, pwr, lo, c, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nfr = 0; rearm_err = 0;
    min_su = 1000000; min_ho = 1000000; min_hi = 1000000; min_lo = 1000000;
  endtask

  task automatic issue(input logic [1:0] op, input bit fast, input logic [9:0] a, input logic [9:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_fast = fast; req_code_a = a; req_code_b = b;
    @(negedge clk);
    chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R10", "done pulse seen", 32'(seen), 32'd1);
    chk(!busy, "R10", "busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(!done, "R10", "done lasts one cycle", 32'(done), 32'd0);
    chk(dac_sclk == 1'b1, "R8", "sclk rests high", 32'(dac_sclk), 32'd1);
  endtask

  task automatic chk_frame(input int idx, input logic [15:0] exp, input string req);
    chk(fr_bits[idx] == 16, "R2", "bits per frame", 32'(fr_bits[idx]), 32'd16);
    chk(fr_word[idx] == exp, req, "frame word", 32'(fr_word[idx]), 32'(exp));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dac_cs_n == 1'b1 && dac_sclk == 1'b1, "R1", "pins in reset", {dac_cs_n, dac_sclk}, 32'h3);
    chk(!busy && !done, "R1", "handshake in reset", {busy, done}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_cs_n == 1'b1 && dac_sclk == 1'b1, "R1", "pins after reset", {dac_cs_n, dac_sclk}, 32'h3);
    chk(!busy && !done, "R1", "handshake after reset", {busy, done}, 32'h0);
    clear_mon();
  endtask

  task automatic t_set_a(input bit fast, input logic [9:0] a);
    clear_mon();
    issue(2'd0, fast, a, 10'h155);
    wait_done();
    chk(nfr == 1, "R4", "set A frame count", 32'(nfr), 32'd1);
    chk_frame(0, mkw(1, 0, fast, 0, a), "R4 R3");
  endtask

  task automatic t_set_b(input bit fast, input logic [9:0] b);
    clear_mon();
    issue(2'd1, fast, 10'h2AA, b);
    wait_done();
    chk(nfr == 1, "R4", "set B frame count", 32'(nfr), 32'd1);
    chk_frame(0, mkw(0, 0, fast, 0, b), "R4 R3");
  endtask

  task automatic t_both(input bit fast, input logic [9:0] a, input logic [9:0] b);
    clear_mon();
    issue(2'd2, fast, a, b);
    wait_done();
    chk(nfr == 2, "R5", "both frame count", 32'(nfr), 32'd2);
    chk_frame(0, mkw(0, 1, fast, 0, b), "R5 buffer word");
    chk_frame(1, mkw(1, 0, fast, 0, a), "R5 A word");
    chk(rearm_err == 0, "R8", "rearm between frames", 32'(rearm_err), 32'd0);
  endtask

  task automatic t_pdown(input bit fast, input logic [9:0] b);
    clear_mon();
    issue(2'd3, fast, 10'h3FF, b);
    wait_done();
    chk(nfr == 1, "R6", "power-down frame count", 32'(nfr), 32'd1);
    chk(fr_word[0][13] == 1'b1, "R6", "power-down bit", 32'(fr_word[0][13]), 32'd1);
    chk_frame(0, mkw(0, 1, fast, 1, b), "R6");
  endtask

  task automatic t_timing();
    clear_mon();
    issue(2'd2, 1'b1, 10'h0F0, 10'h30F);
    wait_done();
    chk(min_su >= SU + HALF, "R7", "select to first fall", 32'(min_su), 32'(SU + HALF));
    chk(min_ho >= HO, "R7", "last fall to deselect", 32'(min_ho), 32'(HO));
    chk(min_hi >= HALF, "R9", "min high phase", 32'(min_hi), 32'(HALF));
    chk(min_lo >= HALF, "R9", "min low phase", 32'(min_lo), 32'(HALF));
    chk(rearm_err == 0, "R8", "rearm edge present", 32'(rearm_err), 32'd0);
  endtask

  task automatic t_ignore_busy();
    clear_mon();
    issue(2'd0, 1'b0, 10'h2C3, 10'h000);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_code_b = 10'h11D;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    chk(nfr == 1, "R10", "request while busy ignored", 32'(nfr), 32'd1);
    chk(fr_word[0] == mkw(1, 0, 0, 0, 10'h2C3), "R10", "only first word sent", 32'(fr_word[0]), 32'(mkw(1, 0, 0, 0, 10'h2C3)));
    chk(!busy, "R10", "idle after ignored request", 32'(busy), 32'd0);
  endtask

  task automatic t_back_to_back();
    bit seen = 0;
    clear_mon();
    issue(2'd0, 1'b1, 10'h0AB, 10'h000);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_fast = 1'b0; req_code_b = 10'h3C5;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R10", "first done seen", 32'(seen), 32'd1);
    @(negedge clk);
    chk(busy == 1'b1, "R10", "request taken right after done", 32'(busy), 32'd1);
    req_valid = 1'b0;
    wait_done();
    chk(nfr == 2, "R10", "back-to-back frame count", 32'(nfr), 32'd2);
    chk_frame(0, mkw(1, 0, 1, 0, 10'h0AB), "R4 first op");
    chk_frame(1, mkw(0, 0, 0, 0, 10'h3C5), "R4 second op");
    chk(rearm_err == 0, "R8", "rearm before next select", 32'(rearm_err), 32'd0);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    finish_up();
  end

  initial begin
    t_reset();
    t_set_a(1'b1, 10'h3FF);
    t_set_a(1'b0, 10'h000);
    t_set_b(1'b0, 10'h2A5);
    t_set_b(1'b1, 10'h15A);
    t_both(1'b0, 10'h123, 10'h2DC);
    t_pdown(1'b0, 10'h2DC);
    t_timing();
    t_ignore_busy();
    t_back_to_back();
    finish_up();
  end

endmodule